// File: doc/BRIEF.md
# Programmable-Action Watchdog Timer

This block is a watchdog peripheral with two 32-bit registers on a simple single-cycle register port. Software arms or refreshes it by writing a tick count into the timer register. That write loads a down-counter, which then loses one per cycle in which the watchdog clock-enable `tick_en` is high. When the counter drops from one to zero, the block takes the expiry response chosen in the control register. The response is one of four: do nothing, raise a level interrupt, raise a level non-maskable interrupt, or request a full chip reset with a fixed-length pulse.

A cause flag records that the watchdog itself requested the last chip reset. Software can read this flag in the control register after the system comes back. The flag is cleared only by power-on reset (`por`). The ordinary reset (`rst`), which the chip reset controller drives in answer to the pulse, leaves it alone. A refresh reaches the counter only after a short fixed load pipeline. While a refresh is in flight, the counter is frozen, so a stale count can never fire.

Top module: `wdog_core`

## Requirements
- R1: The control register is at byte address 0x0 and the timer register is at 0x4. Control reads as bit 31 = cause flag, bits [1:0] = action, and all other bits 0. Any other address reads 0 and ignores writes. Read data is registered and appears one cycle after the address is presented.
- R2: A timer write loads the counter LOAD_LAT (default 2) clock edges after the write edge. Reading the timer returns the current count.
- R3: While a timer load is in the pipeline, the counter neither decrements nor expires, so a new action can never fire on the count that was there before the refresh.
- R4: The counter decrements by one on each edge with `tick_en` high and stops at zero. Loading zero produces no expiry.
- R5: Action 1 sets `irq_o` on the edge where the count goes from 1 to 0. It stays high until a timer write or a control write with action 0.
- R6: Action 2 sets `nmi_o` in the same way, with the same clearing rules.
- R7: Action 3 drives `chip_rst_req_o` high for exactly RST_PULSE (default 4) consecutive cycles, starting on the expiry edge.
- R8: With action 0, expiry changes no output. Writing action 0 disarms the block.
- R9: The cause flag is set on an action-3 expiry. It survives `rst`, is cleared only by `por`, and ignores writes to bit 31.
- R10: After reset the counter and action are 0 and all three request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high system reset (keeps the cause flag) |
| por | input | 1 | Synchronous active-high power-on reset (clears everything) |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| addr | input | ADDR_W (3) | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Level interrupt request |
| nmi_o | output | 1 | Level non-maskable interrupt request |
| chip_rst_req_o | output | 1 | Chip reset request pulse |

## Verification
The properties assume that `rst` and `por` are synchronous and that nothing outside the block changes the count. The count may therefore move only by a pipeline load or by a single-step decrement. They also assume that `por` is the only event allowed to lower the cause flag. The stimulus drives every input on the falling edge and uses only the two defined addresses, except for one deliberate access to an unused one. It holds `tick_en` low whenever the exact count is read back, so every expected value follows from counting edges after a write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_RESET = 2'd3
  } wd_action_e;

  localparam int CTRL_OFS  = 0;
  localparam int TIMER_OFS = 4;
  localparam int CAUSE_BIT = 31;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cnt,
  input  logic              cause,
  output wd_action_e        action_o,
  output logic              timer_wr_o,
  output logic [DATA_W-1:0] timer_data_o,
  output logic              disarm_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic sel_ctrl, sel_tmr;
  logic [DATA_W-1:0] ctrl_word;

  assign sel_ctrl     = (addr == ADDR_W'(CTRL_OFS));
  assign sel_tmr      = (addr == ADDR_W'(TIMER_OFS));
  assign timer_wr_o   = wr_en && sel_tmr;
  assign timer_data_o = wr_data;
  assign disarm_o     = wr_en && sel_ctrl && (wr_data[1:0] == ACT_NONE);

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CAUSE_BIT] = cause;
    ctrl_word[1:0]       = action_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      action_o <= ACT_NONE;
    end else if (wr_en && sel_ctrl) begin
      action_o <= wd_action_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (sel_ctrl) begin
      rd_data_o <= ctrl_word;
    end else if (sel_tmr) begin
      rd_data_o <= cnt;
    end else begin
      rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 32,
  parameter int LOAD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_now_o,
  output logic             expire_o
);
  logic [LOAD_LAT-1:0] stg_vld;
  logic [CNT_W-1:0]    stg_dat [LOAD_LAT];
  logic                busy, dec;

  always_ff @(posedge clk) begin
    if (rst) stg_vld[0] <= 1'b0;
    else     stg_vld[0] <= load_req;
    stg_dat[0] <= load_val;
  end

  for (genvar g = 1; g < LOAD_LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_vld[g] <= 1'b0;
      else     stg_vld[g] <= stg_vld[g-1];
      stg_dat[g] <= stg_dat[g-1];
    end
  end

  assign busy       = |stg_vld;
  assign load_now_o = stg_vld[LOAD_LAT-1];
  assign dec        = tick_en && !busy && (cnt_o != '0);
  assign expire_o   = dec && (cnt_o == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (load_now_o) begin
      cnt_o <= stg_dat[LOAD_LAT-1];
    end else if (dec) begin
      cnt_o <= cnt_o - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por,
  input  logic       expire,
  input  wd_action_e action,
  input  logic       timer_wr,
  input  logic       disarm,
  output logic       irq_o,
  output logic       nmi_o,
  output logic       req_o,
  output logic       cause_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] pulse_cnt;
  logic          clr_lvl, fire_rst;

  assign clr_lvl  = timer_wr || disarm;
  assign fire_rst = expire && (action == ACT_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else if (clr_lvl) begin
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else if (expire) begin
      if (action == ACT_IRQ) irq_o <= 1'b1;
      if (action == ACT_NMI) nmi_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_cnt <= '0;
      req_o     <= 1'b0;
    end else if (fire_rst) begin
      pulse_cnt <= PW'(RST_PULSE);
      req_o     <= 1'b1;
    end else if (pulse_cnt > PW'(1)) begin
      pulse_cnt <= pulse_cnt - PW'(1);
    end else if (pulse_cnt == PW'(1)) begin
      pulse_cnt <= '0;
      req_o     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por)           cause_o <= 1'b0;
    else if (fire_rst) cause_o <= 1'b1;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int LOAD_LAT  = 2,
  parameter int RST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              chip_rst_req_o
);
  logic              rst_any;
  wd_action_e        action_w;
  logic              timer_wr_w, disarm_w, load_now_w, expire_w, cause_w;
  logic [DATA_W-1:0] timer_data_w, cnt_w;

  assign rst_any = rst || por;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst_any), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .cnt(cnt_w), .cause(cause_w), .action_o(action_w), .timer_wr_o(timer_wr_w),
    .timer_data_o(timer_data_w), .disarm_o(disarm_w), .rd_data_o(rd_data)
  );

  wdog_counter #(.CNT_W(DATA_W), .LOAD_LAT(LOAD_LAT)) u_cnt (
    .clk(clk), .rst(rst_any), .tick_en(tick_en), .load_req(timer_wr_w),
    .load_val(timer_data_w), .cnt_o(cnt_w), .load_now_o(load_now_w),
    .expire_o(expire_w)
  );

  wdog_action #(.RST_PULSE(RST_PULSE)) u_act (
    .clk(clk), .rst(rst_any), .por(por), .expire(expire_w), .action(action_w),
    .timer_wr(timer_wr_w), .disarm(disarm_w), .irq_o(irq_o), .nmi_o(nmi_o),
    .req_o(chip_rst_req_o), .cause_o(cause_w)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             chip_rst_req_o,
  input logic [CNT_W-1:0] cnt,
  input logic             load_now,
  input logic             cause
);
  // R4
  cnt_floor_chk: assert property (@(posedge clk) disable iff (rst || por)
    (cnt == '0 && !load_now) |=> (cnt == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst || por)
    !load_now |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

  // R5
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst || por)
    $rose(irq_o) |-> (cnt == '0 && $past(cnt) == CNT_W'(1)));

  // R6
  nmi_edge_chk: assert property (@(posedge clk) disable iff (rst || por)
    $rose(nmi_o) |-> (cnt == '0 && $past(cnt) == CNT_W'(1)));

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (rst || por)
    $rose(chip_rst_req_o) |-> cause);

  // R9
  cause_keep_chk: assert property (@(posedge clk) disable iff (por)
    cause |=> cause);
endmodule

bind wdog_core wdog_chk #(.CNT_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .por(por), .irq_o(irq_o), .nmi_o(nmi_o),
  .chip_rst_req_o(chip_rst_req_o), .cnt(cnt_w), .load_now(load_now_w),
  .cause(cause_w)
);

// File: tb/wdog_core_tb.sv
`timescale 1ns/1ps
module wdog_core_tb_top;
  logic        clk = 1'b0;
  logic        rst, por, tick_en, wr_en;
  logic [2:0]  addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_o, nmi_o, chip_rst_req_o;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  wdog_core dut_i (
    .clk(clk), .rst(rst), .por(por), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o),
    .nmi_o(nmi_o), .chip_rst_req_o(chip_rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 irq", {31'd0, irq_o}, 0);
    chk("R10 nmi", {31'd0, nmi_o}, 0);
    chk("R10 req", {31'd0, chip_rst_req_o}, 0);
    bus_rd(3'd0, d); chk("R10 ctrl", d, 0);
    bus_rd(3'd4, d); chk("R10 timer", d, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    bus_wr(3'd4, 32'h1234); wait_cyc(3);
    bus_rd(3'd4, d); chk("R2 timer readback", d, 32'h1234);
    bus_wr(3'd2, 32'h3);
    bus_rd(3'd0, d); chk("R1 unused write ignored", d, 0);
    bus_rd(3'd2, d); chk("R1 unused read", d, 0);
    bus_wr(3'd0, 32'h2);
    bus_rd(3'd0, d); chk("R1 ctrl action field", d, 32'h2);
    bus_wr(3'd0, 32'h0);
  endtask

  task automatic t_latency;
    bus_wr(3'd4, 32'd77);
    wait_cyc(2); chk("R2 old count before load", rd_data, 32'h1234);
    wait_cyc(1); chk("R2 new count after load", rd_data, 32'd77);
  endtask

  task automatic t_guard;
    logic [31:0] d;
    bus_wr(3'd4, 32'd1); wait_cyc(3);
    bus_wr(3'd0, 32'd1);
    bus_wr(3'd4, 32'd50);
    tick_en = 1'b1;
    wait_cyc(10);
    tick_en = 1'b0;
    chk("R3 stale count did not fire", {31'd0, irq_o}, 0);
    bus_rd(3'd4, d); chk("R3 frozen during load", d, 32'd42);
    bus_wr(3'd0, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    bus_wr(3'd4, 32'd20); wait_cyc(3);
    tick_en = 1'b1; wait_cyc(5); tick_en = 1'b0;
    bus_rd(3'd4, d); chk("R4 five ticks", d, 32'd15);
    bus_wr(3'd0, 32'd1);
    bus_wr(3'd4, 32'd0);
    tick_en = 1'b1; wait_cyc(10); tick_en = 1'b0;
    chk("R4 zero load no expiry", {31'd0, irq_o}, 0);
    bus_rd(3'd4, d); chk("R4 stays at zero", d, 0);
    bus_wr(3'd0, 32'd0);
  endtask

  task automatic t_irq;
    bus_wr(3'd0, 32'd1);
    tick_en = 1'b1;
    bus_wr(3'd4, 32'd10);
    wait_cyc(11); chk("R5 irq low before expiry", {31'd0, irq_o}, 0);
    wait_cyc(1);  chk("R5 irq at expiry", {31'd0, irq_o}, 1);
    chk("R5 no nmi", {31'd0, nmi_o}, 0);
    wait_cyc(5);  chk("R5 irq level held", {31'd0, irq_o}, 1);
    bus_wr(3'd4, 32'd1000); chk("R5 timer write clears", {31'd0, irq_o}, 0);
    bus_wr(3'd4, 32'd3);
    wait_cyc(5);  chk("R5 irq again", {31'd0, irq_o}, 1);
    bus_wr(3'd0, 32'd0); chk("R5 disarm clears", {31'd0, irq_o}, 0);
  endtask

  task automatic t_nmi;
    bus_wr(3'd0, 32'd2);
    bus_wr(3'd4, 32'd4);
    wait_cyc(5); chk("R6 nmi low before expiry", {31'd0, nmi_o}, 0);
    wait_cyc(1); chk("R6 nmi at expiry", {31'd0, nmi_o}, 1);
    chk("R6 no irq", {31'd0, irq_o}, 0);
    bus_wr(3'd0, 32'd0); chk("R6 disarm clears", {31'd0, nmi_o}, 0);
  endtask

  task automatic t_none;
    logic [31:0] d;
    bus_wr(3'd0, 32'd1);
    bus_wr(3'd4, 32'd6); wait_cyc(2);
    bus_wr(3'd0, 32'd0);
    wait_cyc(10);
    chk("R8 no irq", {31'd0, irq_o}, 0);
    chk("R8 no nmi", {31'd0, nmi_o}, 0);
    chk("R8 no req", {31'd0, chip_rst_req_o}, 0);
    tick_en = 1'b0;
    bus_rd(3'd4, d); chk("R8 counter still ran out", d, 0);
  endtask

  task automatic t_chip_reset;
    logic [31:0] d;
    tick_en = 1'b1;
    bus_wr(3'd0, 32'd3);
    bus_wr(3'd4, 32'd5);
    wait_cyc(6); chk("R7 req low before expiry", {31'd0, chip_rst_req_o}, 0);
    for (int i = 0; i < 4; i++) begin
      wait_cyc(1); chk("R7 req pulse", {31'd0, chip_rst_req_o}, 1);
    end
    wait_cyc(1); chk("R7 req pulse end", {31'd0, chip_rst_req_o}, 0);
    tick_en = 1'b0;
    bus_rd(3'd0, d); chk("R9 cause set", d, 32'h8000_0003);
    rst = 1'b1; wait_cyc(1); rst = 1'b0;
    bus_rd(3'd0, d); chk("R9 cause survives rst", d, 32'h8000_0000);
    bus_wr(3'd0, 32'h0);
    bus_rd(3'd0, d); chk("R9 bit31 write ignored", d, 32'h8000_0000);
    por = 1'b1; wait_cyc(1); por = 1'b0;
    bus_rd(3'd0, d); chk("R9 por clears cause", d, 0);
    bus_wr(3'd0, 32'h8000_0001);
    bus_rd(3'd0, d); chk("R9 bit31 cannot be set", d, 32'h1);
    bus_wr(3'd0, 32'h0);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; por = 1'b1; tick_en = 1'b0; wr_en = 1'b0;
    addr = '0; wr_data = '0;
    wait_cyc(3);
    rst = 1'b0; por = 1'b0;
    t_reset();
    t_map();
    t_latency();
    t_guard();
    t_count();
    t_irq();
    t_nmi();
    t_none();
    t_chip_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule